// File: doc/BRIEF.md
# Streaming Chirp Z-Transform Engine

This block evaluates a chirp z-transform on frames of complex fixed-point samples. A frame of N time samples is streamed in. Each sample is scaled by a per-index complex coefficient as it arrives. The scaled sequence is then convolved with a causal chirp kernel of L+N-1 taps. Each kept convolution result is multiplied by a second per-index coefficient, and one common power-of-two gain is applied at the end. L frequency words leave on an output stream, and the final word carries a last flag.

The three coefficient tables and a small set of control values (N, L and the output gain shift) share one write port. All writes are refused while a frame is in flight. N and L are independent run-time values, bounded by the parameters NMAX and LMAX, and neither has to be a power of two. A plain DFT of length N is obtained by loading unit-magnitude chirp coefficients with a start angle of zero and a step angle of 2π/N, with L set equal to N. Stored coefficient magnitudes never exceed one. Any gain above unity is carried by the output shift.

Both data interfaces use valid/ready. A word moves on a rising edge only when valid and ready are both high. The input side cannot take a new frame while results of the current one are still pending. The output side holds each word, unchanged, for as long as out_ready stays low.

Top module: `czt_engine`

## Requirements
- R1: After reset, in_ready is 1, out_valid and out_last are 0, N = NMAX, L = LMAX, the output shift is 0 and every table entry is zero, so a frame produces all-zero outputs.
- R2: An input word is taken on a rising edge with in_valid and in_ready high. in_ready is low from the edge that takes the N-th sample of a frame until the edge that hands over that frame's final output, and is high again right after that edge.
- R3: Each accepted sample x[n] (n = 0..N-1) is turned into g[n] = q(x[n]·P[n]), where P is the pre table. The complex product is formed exactly (re = ar·br − ai·bi, im = ar·bi + ai·br, Q1.15 operands), and q(v) = clamp(floor((v + 2^14) / 2^15)) to [−32768, 32767].
- R4: For output j (0..L−1) the convolution value is y = q(Σ_{k=0..N−1} g[k]·F[j+N−1−k]), with the sum kept exact and rounded once. F is the filter table and uses entries 0..L+N−2.
- R5: Output j equals clamp(q(y·Q[j]) · 2^S), where Q is the post table, S is the output shift (0..15), and clamp is the same 16-bit clamp.
- R6: A frame emits exactly L words, in the order j = 0..L−1. out_last is high only on word L−1. The N−1 leading convolution results are never emitted.
- R7: While out_valid is high and out_ready is low, out_valid, out_re, out_im and out_last hold their values.
- R8: Writes on the coefficient port are ignored from the first accepted sample of a frame until the frame's final output is handed over.
- R9: Writes to the control table use cw_sel = 3. Address 0 sets N from cw_re and is ignored unless 1 ≤ cw_re ≤ NMAX. Address 1 sets L and is ignored unless 1 ≤ cw_re ≤ LMAX. Address 2 sets S from cw_re[3:0]. cw_sel = 0, 1 and 2 write P, F and Q at cw_addr, with real part cw_re and imaginary part cw_im.
- R10: Results that exceed the 16-bit range after the shift saturate to 32767 or −32768 and do not wrap.
- R11: N and L may differ and need not be powers of two, and the extremes N = L = 1 and N = NMAX, L = LMAX are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Coefficient/control write strobe |
| cw_sel | input | 2 | Target: 0 pre, 1 filter, 2 post, 3 control |
| cw_addr | input | IW (4) | Entry index within the target |
| cw_re | input | 16 | Real part or control value |
| cw_im | input | 16 | Imaginary part |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine accepts an input sample |
| in_re | input | 16 | Input sample, real, Q1.15 |
| in_im | input | 16 | Input sample, imaginary, Q1.15 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_re | output | 16 | Output word, real, Q1.15 |
| out_im | output | 16 | Output word, imaginary, Q1.15 |
| out_last | output | 1 | Marks word L−1 of a frame |

## Verification
The properties assume that out_ready is a level from a downstream that may stall for any number of cycles, and that the coefficient port is used with an in-range N and L, which the block enforces itself. They make no assumption about in_valid outside handshakes. The stimulus changes every input only between clock edges. It holds out_ready low for a cycle to exercise stalls, and it issues control and table writes both while idle and in mid-frame, so the refusal and range rules are exercised through the output data rather than through internal state.

// File: rtl/czt_pkg.sv
`timescale 1ns/1ps
package czt_pkg;
  localparam int SW   = 16;
  localparam int FRAC = 15;

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  typedef enum logic [1:0] {
    TBL_PRE  = 2'd0,
    TBL_FIR  = 2'd1,
    TBL_POST = 2'd2,
    TBL_CTRL = 2'd3
  } tbl_sel_e;

  function automatic logic signed [SW-1:0] clamp16(input logic signed [63:0] v);
    if (v > 64'sd32767)  return 16'sh7fff;
    if (v < -64'sd32768) return 16'sh8000;
    return SW'(v);
  endfunction

  // round half up at the Q1.15 boundary, then clamp
  function automatic logic signed [SW-1:0] rnd_q15(input logic signed [63:0] v);
    logic signed [63:0] t;
    t = (v + (64'sd1 <<< (FRAC-1))) >>> FRAC;
    return clamp16(t);
  endfunction
endpackage

// File: rtl/czt_cmul.sv
`timescale 1ns/1ps
module czt_cmul
  import czt_pkg::*;
#(
  parameter int PW = 2*SW + 1
) (
  input  cplx_t                a,
  input  cplx_t                b,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);
  logic signed [2*SW-1:0] rr, ii, ri, ir;

  always_comb begin
    rr   = a.re * b.re;
    ii   = a.im * b.im;
    ri   = a.re * b.im;
    ir   = a.im * b.re;
    p_re = PW'(rr) - PW'(ii);
    p_im = PW'(ri) + PW'(ir);
  end
endmodule

// File: rtl/czt_coef_store.sv
`timescale 1ns/1ps
module czt_coef_store
  import czt_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int LMAX = 8,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  tbl_sel_e      sel,
  input  logic [IW-1:0] addr,
  input  cplx_t         wr_val,
  input  logic [IW-1:0] pre_idx,
  input  logic [IW-1:0] fir_idx,
  input  logic [IW-1:0] post_idx,
  output cplx_t         pre_c,
  output cplx_t         fir_c,
  output cplx_t         post_c,
  output logic [IW-1:0] n_cfg,
  output logic [IW-1:0] l_cfg,
  output logic [3:0]    shift_cfg
);
  localparam int HMAX = NMAX + LMAX - 1;

  cplx_t pre_t  [NMAX];
  cplx_t fir_t  [HMAX];
  cplx_t post_t [LMAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMAX; i++) pre_t[i]  <= '0;
      for (int i = 0; i < HMAX; i++) fir_t[i]  <= '0;
      for (int i = 0; i < LMAX; i++) post_t[i] <= '0;
      n_cfg     <= IW'(NMAX);
      l_cfg     <= IW'(LMAX);
      shift_cfg <= '0;
    end else if (wr_en) begin
      case (sel)
        TBL_PRE:  for (int i = 0; i < NMAX; i++) if (addr == IW'(i)) pre_t[i]  <= wr_val;
        TBL_FIR:  for (int i = 0; i < HMAX; i++) if (addr == IW'(i)) fir_t[i]  <= wr_val;
        TBL_POST: for (int i = 0; i < LMAX; i++) if (addr == IW'(i)) post_t[i] <= wr_val;
        TBL_CTRL: begin
          if (addr == IW'(0) && int'(wr_val.re) >= 1 && int'(wr_val.re) <= NMAX)
            n_cfg <= IW'(wr_val.re);
          if (addr == IW'(1) && int'(wr_val.re) >= 1 && int'(wr_val.re) <= LMAX)
            l_cfg <= IW'(wr_val.re);
          if (addr == IW'(2))
            shift_cfg <= wr_val.re[3:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pre_c  = '0;
    fir_c  = '0;
    post_c = '0;
    for (int i = 0; i < NMAX; i++) if (pre_idx  == IW'(i)) pre_c  = pre_t[i];
    for (int i = 0; i < HMAX; i++) if (fir_idx  == IW'(i)) fir_c  = fir_t[i];
    for (int i = 0; i < LMAX; i++) if (post_idx == IW'(i)) post_c = post_t[i];
  end
endmodule

// File: rtl/czt_engine.sv
`timescale 1ns/1ps
module czt_engine
  import czt_pkg::*;
#(
  parameter int NMAX = 8,
  parameter int LMAX = 8,
  localparam int IW  = $clog2(NMAX + LMAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cw_en,
  input  logic [1:0]           cw_sel,
  input  logic [IW-1:0]        cw_addr,
  input  logic signed [SW-1:0] cw_re,
  input  logic signed [SW-1:0] cw_im,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_re,
  input  logic signed [SW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] out_re,
  output logic signed [SW-1:0] out_im,
  output logic                 out_last
);
  localparam int PW  = 2*SW + 1;
  localparam int ACW = PW + $clog2(NMAX) + 1;

  typedef enum logic [1:0] {ST_LOAD, ST_MAC, ST_HOLD} st_e;
  st_e state;

  logic [IW-1:0] idx, k, j, fir_idx;
  logic [IW-1:0] n_cfg, l_cfg;
  logic [3:0]    shift_cfg;
  logic          busy;
  cplx_t         pre_c, fir_c, post_c, x_c, g_new, g_k, y_c;
  cplx_t         g_mem [NMAX];
  logic signed [PW-1:0]  pre_re, pre_im, mac_re, mac_im, pst_re, pst_im;
  logic signed [ACW-1:0] acc_re, acc_im, nxt_re, nxt_im;
  logic signed [SW-1:0]  p_re, p_im, fin_re, fin_im;

  assign busy     = (state != ST_LOAD) || (idx != '0);
  assign in_ready = (state == ST_LOAD);
  assign out_valid = (state == ST_HOLD);
  assign out_last  = (state == ST_HOLD) && (j == l_cfg - IW'(1));
  assign fir_idx  = j + n_cfg - IW'(1) - k;
  assign x_c      = {in_re, in_im};

  czt_coef_store #(.NMAX(NMAX), .LMAX(LMAX), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cw_en && !busy), .sel(tbl_sel_e'(cw_sel)), .addr(cw_addr),
    .wr_val({cw_re, cw_im}),
    .pre_idx(idx), .fir_idx(fir_idx), .post_idx(j),
    .pre_c(pre_c), .fir_c(fir_c), .post_c(post_c),
    .n_cfg(n_cfg), .l_cfg(l_cfg), .shift_cfg(shift_cfg)
  );

  // stage 1: pre-chirp on arrival
  czt_cmul #(.PW(PW)) u_pre  (.a(x_c), .b(pre_c),  .p_re(pre_re), .p_im(pre_im));
  // stage 2: one tap per cycle
  czt_cmul #(.PW(PW)) u_mac  (.a(g_k), .b(fir_c),  .p_re(mac_re), .p_im(mac_im));
  // stage 3: post-chirp on the finished sum
  czt_cmul #(.PW(PW)) u_post (.a(y_c), .b(post_c), .p_re(pst_re), .p_im(pst_im));

  always_comb begin
    g_new.re = rnd_q15(64'(pre_re));
    g_new.im = rnd_q15(64'(pre_im));
    g_k = '0;
    for (int i = 0; i < NMAX; i++) if (k == IW'(i)) g_k = g_mem[i];
    nxt_re = acc_re + ACW'(mac_re);
    nxt_im = acc_im + ACW'(mac_im);
    y_c.re = rnd_q15(64'(nxt_re));
    y_c.im = rnd_q15(64'(nxt_im));
    p_re   = rnd_q15(64'(pst_re));
    p_im   = rnd_q15(64'(pst_im));
    fin_re = clamp16(64'(p_re) <<< shift_cfg);
    fin_im = clamp16(64'(p_im) <<< shift_cfg);
  end

  always_ff @(posedge clk) begin
    if (state == ST_LOAD && in_valid)
      for (int i = 0; i < NMAX; i++) if (idx == IW'(i)) g_mem[i] <= g_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      idx    <= '0;
      k      <= '0;
      j      <= '0;
      acc_re <= '0;
      acc_im <= '0;
      out_re <= '0;
      out_im <= '0;
    end else begin
      case (state)
        ST_LOAD: if (in_valid) begin
          if (idx == n_cfg - IW'(1)) begin
            idx    <= '0;
            k      <= '0;
            j      <= '0;
            acc_re <= '0;
            acc_im <= '0;
            state  <= ST_MAC;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        ST_MAC: begin
          if (k == n_cfg - IW'(1)) begin
            out_re <= fin_re;
            out_im <= fin_im;
            state  <= ST_HOLD;
          end else begin
            k      <= k + IW'(1);
            acc_re <= nxt_re;
            acc_im <= nxt_im;
          end
        end
        ST_HOLD: if (out_ready) begin
          k      <= '0;
          acc_re <= '0;
          acc_im <= '0;
          if (j == l_cfg - IW'(1)) begin
            state <= ST_LOAD;
          end else begin
            j     <= j + IW'(1);
            state <= ST_MAC;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/czt_engine_chk.sv
`timescale 1ns/1ps
module czt_engine_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic signed [15:0] out_re,
  input logic signed [15:0] out_im,
  input logic               out_last
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R2
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready);

  // R6
  next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> !out_valid && !in_ready);

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind czt_engine czt_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .out_last(out_last)
);

// File: tb/test_czt_engine.sv
`timescale 1ns/1ps
module test_czt_engine;
  localparam int NMAX = 8;
  localparam int LMAX = 8;
  localparam int HMAX = NMAX + LMAX - 1;
  localparam int IW   = $clog2(NMAX + LMAX);

  logic clk = 0;
  logic rst_n = 0;
  logic cw_en = 0;
  logic [1:0] cw_sel = 0;
  logic [IW-1:0] cw_addr = 0;
  logic signed [15:0] cw_re = 0, cw_im = 0;
  logic in_valid = 0;
  logic in_ready;
  logic signed [15:0] in_re = 0, in_im = 0;
  logic out_valid;
  logic out_ready = 0;
  logic signed [15:0] out_re, out_im;
  logic out_last;

  always #2.5 clk = ~clk;

  czt_engine i_czt_engine (
    .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_sel(cw_sel), .cw_addr(cw_addr),
    .cw_re(cw_re), .cw_im(cw_im), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1357_9bdf;
  longint pre_r[NMAX], pre_i[NMAX], fir_r[HMAX], fir_i[HMAX], post_r[LMAX], post_i[LMAX];
  longint xr[NMAX], xi[NMAX];
  int mn = NMAX, ml = LMAX, msh = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rq(input longint v);
    return sat((v + 16384) >>> 15);
  endfunction

  function automatic longint rnd16(input bit big);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return big ? 2 * (longint'(seed[23:9]) - 16384) : longint'(seed[23:9]) - 16384;
  endfunction

  task automatic wr(input int sel, input int addr, input longint re, input longint im);
    @(negedge clk);
    cw_en = 1; cw_sel = 2'(sel); cw_addr = IW'(addr); cw_re = 16'(re); cw_im = 16'(im);
    @(negedge clk);
    cw_en = 0;
  endtask

  task automatic load_tables(input int n, input int l, input int sh, input bit big);
    wr(3, 0, n, 0); wr(3, 1, l, 0); wr(3, 2, sh, 0);
    mn = n; ml = l; msh = sh;
    for (int i = 0; i < n; i++) begin
      pre_r[i] = rnd16(big); pre_i[i] = rnd16(big); wr(0, i, pre_r[i], pre_i[i]);
    end
    for (int i = 0; i < n + l - 1; i++) begin
      fir_r[i] = rnd16(big); fir_i[i] = rnd16(big); wr(1, i, fir_r[i], fir_i[i]);
    end
    for (int i = 0; i < l; i++) begin
      post_r[i] = rnd16(big); post_i[i] = rnd16(big); wr(2, i, post_r[i], post_i[i]);
    end
  endtask

  task automatic fill_x(input bit big);
    for (int i = 0; i < NMAX; i++) begin xr[i] = rnd16(big); xi[i] = rnd16(big); end
  endtask

  task automatic push(input longint re, input longint im);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1; in_re = 16'(re); in_im = 16'(im);
      if (in_ready) done = 1;
    end
    @(posedge clk);
  endtask

  task automatic run_frame(input string req, input bit bp, input bit busy_wr);
    longint gr[NMAX], gi[NMAX];
    for (int n = 0; n < mn; n++) begin
      gr[n] = rq(xr[n] * pre_r[n] - xi[n] * pre_i[n]);
      gi[n] = rq(xr[n] * pre_i[n] + xi[n] * pre_r[n]);
    end
    for (int n = 0; n < mn; n++) push(xr[n], xi[n]);
    @(negedge clk);
    in_valid = 0;
    check(in_ready == 0, "R2", "in_ready after N-th sample", in_ready, 0);
    if (busy_wr) begin
      // R8: table and N writes while the frame is in flight
      cw_en = 1; cw_sel = 0; cw_addr = 0; cw_re = 16'sh1234; cw_im = 16'sh0777;
      @(negedge clk);
      cw_sel = 3; cw_addr = 0; cw_re = 16'((mn == 1) ? 2 : 1);
      @(negedge clk);
      cw_en = 0;
    end
    for (int j = 0; j < ml; j++) begin
      longint sr = 0, si = 0, yr, yi, p_r, p_i, er, ei, hr, hi;
      for (int k = 0; k < mn; k++) begin
        int m = j + mn - 1 - k;
        sr += gr[k] * fir_r[m] - gi[k] * fir_i[m];
        si += gr[k] * fir_i[m] + gi[k] * fir_r[m];
      end
      yr = rq(sr); yi = rq(si);
      p_r = rq(yr * post_r[j] - yi * post_i[j]);
      p_i = rq(yr * post_i[j] + yi * post_r[j]);
      er = sat(p_r <<< msh); ei = sat(p_i <<< msh);
      @(negedge clk);
      out_ready = 0;
      while (!out_valid) @(negedge clk);
      check(in_ready == 0, "R2", "in_ready while output pending", in_ready, 0);
      if (bp) begin
        hr = out_re; hi = out_im;
        @(negedge clk);
        check(out_valid && out_re == hr && out_im == hi, "R7", "held word under stall",
              longint'(out_re), hr);
      end
      out_ready = 1;
      check(out_re == er, req, $sformatf("word %0d real", j), longint'(out_re), er);
      check(out_im == ei, req, $sformatf("word %0d imag", j), longint'(out_im), ei);
      check(out_last == (j == ml - 1), "R6", $sformatf("out_last on word %0d", j),
            longint'(out_last), longint'(j == ml - 1));
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 0;
    check(in_ready == 1, "R2", "in_ready after final word", in_ready, 1);
  endtask

  task automatic t_reset();
    check(in_ready == 1, "R1", "in_ready at reset", in_ready, 1);
    check(out_valid == 0, "R1", "out_valid at reset", out_valid, 0);
    check(out_last == 0, "R1", "out_last at reset", out_last, 0);
    fill_x(0);
    run_frame("R1", 0, 0);   // zero tables, NMAX x LMAX frame
  endtask

  task automatic t_basic();
    load_tables(4, 4, 0, 0);
    fill_x(0);
    run_frame("R4", 0, 0);
    fill_x(1);
    run_frame("R3", 0, 0);
  endtask

  task automatic t_edges();
    load_tables(1, 1, 0, 0);
    fill_x(1);
    run_frame("R11", 0, 0);
    load_tables(NMAX, LMAX, 1, 0);
    fill_x(0);
    run_frame("R5", 0, 0);
  endtask

  task automatic t_odd();
    load_tables(3, 5, 1, 0);
    fill_x(1);
    run_frame("R11", 1, 0);
  endtask

  task automatic t_sat();
    load_tables(5, 2, 9, 1);
    fill_x(1);
    run_frame("R10", 0, 0);
  endtask

  task automatic t_busy();
    load_tables(4, 3, 0, 0);
    fill_x(0);
    run_frame("R8", 0, 1);
    fill_x(1);
    run_frame("R8", 1, 0);
  endtask

  task automatic t_badcfg();
    wr(3, 0, 0, 0);
    wr(3, 0, NMAX + 1, 0);
    wr(3, 1, 0, 0);
    wr(3, 1, -1, 0);
    wr(3, 1, LMAX + 1, 0);
    fill_x(0);
    run_frame("R9", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_edges();
    t_odd();
    t_sat();
    t_busy();
    t_badcfg();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule